// File: doc/BRIEF.md
# Eight-bit minifloat adder

This block adds two numbers held in an eight-bit floating-point format and returns their sum in the same format, rounded to the nearest representable value with ties broken toward an even fraction. The format has one sign bit at the top, a four-bit biased exponent in the middle and a three-bit fraction at the bottom. Zeros, denormals, infinities and NaNs are all handled. Overflow saturates to a signed infinity, and any invalid operation returns one fixed NaN pattern.

The datapath is purely combinational. It orders the operands by magnitude, aligns the smaller one with guard, round and sticky bits, adds or subtracts, and normalises without dropping below the denormal exponent. It then rounds and repacks the result. A parameter places an optional register on the result. With the default setting the sum appears one clock after the operands are sampled.

Top module: `minifloat_add`

## Requirements
- R1: Operand bit 7 is the sign, bits 6:3 are the exponent field and bits 2:0 are the fraction. When the exponent field is neither 0 nor 15, the value is (8+frac)/8 × 2^(field−7).
- R2: When the exponent field is 0, the value is frac/8 × 2^−6. Denormals add correctly to denormals and to normals, and a denormal sum may carry into the smallest normal (field 1).
- R3: For two finite operands whose exact sum is nonzero, the output is the representable value nearest that sum, carrying the sum's sign.
- R4: When the exact sum lies exactly halfway between two neighbouring representable values, the output is the one whose fraction bit 0 is 0.
- R5: When the rounded magnitude would reach 256 or more, the output is infinity with the sum's sign: 0x78 for a positive sum, 0xF8 for a negative one. This includes a rounding carry out of field 14.
- R6: If either operand is a NaN (exponent field 15, fraction nonzero), the output is 0x7C.
- R7: Infinity (exponent field 15, fraction 0) plus infinity of the opposite sign gives 0x7C. Infinity plus a finite value, or plus infinity of the same sign, gives that infinity.
- R8: An exact zero from operands of opposite sign gives +0 (0x00). −0 plus −0 gives −0 (0x80), and +0 plus +0 gives 0x00.
- R9: With OUT_REG=1, the output is the sum of the operands sampled at the previous rising clock edge. While rst_n is low, the output is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Active-low asynchronous reset of the result register |
| a_in | input | 8 | First addend |
| b_in | input | 8 | Second addend |
| sum_out | output | 8 | Rounded sum |

## Verification
The assertions assume the operands are stable for a full clock period and rely on a one-cycle record of the operands. They fire only once that record is valid after reset, so the first cycle out of reset is never judged against operands sampled during reset. The stimulus drives each operand pair on the falling edge and holds it across the next rising edge. It walks every one of the 65,536 pairs, so every NaN pattern, infinity, zero sign combination, denormal and halfway case reaches both the assertions and the arithmetic model in the bench.

// File: rtl/minifloat_add.sv
module minifloat_add #(
  parameter int OUT_REG = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] a_in,
  input  logic [7:0] b_in,
  output logic [7:0] sum_out
);
  localparam logic [7:0] QNAN = 8'h7C;

  logic a_nan, b_nan, a_inf, b_inf, swap, sub;
  logic [7:0] big, sml;
  logic [3:0] eb, es, d;
  logic [3:0] sig_b, sig_s;
  logic [13:0] ext;
  logic [6:0] big_al, sml_al;
  logic [7:0] raw;
  logic [6:0] nm;
  logic [4:0] e5, m5;
  logic [3:0] lz, sh;
  logic rup;
  logic [7:0] res;

  assign a_nan = (&a_in[6:3]) & (|a_in[2:0]);
  assign b_nan = (&b_in[6:3]) & (|b_in[2:0]);
  assign a_inf = a_in[6:0] == 7'h78;
  assign b_inf = b_in[6:0] == 7'h78;

  assign swap = b_in[6:0] > a_in[6:0];
  assign big  = swap ? b_in : a_in;
  assign sml  = swap ? a_in : b_in;
  assign sub  = big[7] ^ sml[7];

  assign eb    = (big[6:3] == 4'd0) ? 4'd1 : big[6:3];
  assign es    = (sml[6:3] == 4'd0) ? 4'd1 : sml[6:3];
  assign d     = eb - es;
  assign sig_b = {|big[6:3], big[2:0]};
  assign sig_s = {|sml[6:3], sml[2:0]};

  assign ext    = {sig_s, 10'd0} >> d;
  assign big_al = {sig_b, 3'b000};
  assign sml_al = {ext[13:8], ext[7] | (|ext[6:0])};
  assign raw    = sub ? ({1'b0, big_al} - {1'b0, sml_al})
                      : ({1'b0, big_al} + {1'b0, sml_al});

  always_comb begin
    lz = 4'd7;
    for (int i = 0; i < 7; i++)
      if (raw[i]) lz = 4'(6 - i);
    sh = 4'd0;
    if (raw[7]) begin
      nm = {raw[7:2], raw[1] | raw[0]};
      e5 = {1'b0, eb} + 5'd1;
    end else begin
      sh = (lz < eb - 4'd1) ? lz : eb - 4'd1;
      nm = raw[6:0] << sh;
      e5 = {1'b0, eb} - {1'b0, sh};
    end
    rup = nm[2] & (nm[1] | nm[0] | nm[3]);
    m5  = {1'b0, nm[6:3]} + {4'd0, rup};
    if (m5[4]) begin
      m5 = 5'b01000;
      e5 = e5 + 5'd1;
    end
  end

  always_comb begin
    if (a_nan || b_nan || (a_inf && b_inf && (a_in[7] != b_in[7])))
      res = QNAN;
    else if (a_inf)
      res = a_in;
    else if (b_inf)
      res = b_in;
    else if (raw == 8'd0)
      res = sub ? 8'h00 : {big[7], 7'd0};
    else if (e5 >= 5'd15)
      res = {big[7], 7'h78};
    else
      res = {big[7], (m5[3] ? e5[3:0] : 4'd0), m5[2:0]};
  end

  generate
    if (OUT_REG != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sum_out <= 8'h00;
        else        sum_out <= res;
    end else begin : g_comb
      assign sum_out = res;
    end
  endgenerate
endmodule

module minifloat_add_chk #(
  parameter int OUT_REG = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] a_in,
  input logic [7:0] b_in,
  input logic [7:0] sum_out
);
  logic [7:0] pa, pb, xa, xb;
  logic seen, ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pa <= 8'h00; pb <= 8'h00; seen <= 1'b0;
    end else begin
      pa <= a_in; pb <= b_in; seen <= 1'b1;
    end

  assign xa = (OUT_REG != 0) ? pa : a_in;
  assign xb = (OUT_REG != 0) ? pb : b_in;
  assign ok = (OUT_REG != 0) ? seen : 1'b1;

  AST_NAN_IN: assert property (@(posedge clk) disable iff (!rst_n)
    ok && (((&xa[6:3]) && |xa[2:0]) || ((&xb[6:3]) && |xb[2:0])) |-> sum_out == 8'h7C); // R6
  AST_INF_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    ok && xa[6:0] == 7'h78 && xb == (xa ^ 8'h80) |-> sum_out == 8'h7C); // R7
  AST_INF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ok && xa[6:0] == 7'h78 && xb[6:3] != 4'hF |-> sum_out == xa); // R7
  AST_CANCEL_POS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ok && xa[6:3] != 4'hF && xb == (xa ^ 8'h80) |-> sum_out == 8'h00); // R8
  AST_ADD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ok && xb == 8'h00 && xa != 8'h80 && !((&xa[6:3]) && |xa[2:0]) |-> sum_out == xa); // R3
  AST_CANON_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (&sum_out[6:3]) |-> (sum_out[2:0] == 3'b000 || sum_out == 8'h7C)); // R5
endmodule

bind minifloat_add minifloat_add_chk #(.OUT_REG(OUT_REG)) chk_i (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .sum_out(sum_out)
);

// File: tb/minifloat_add_test.sv
module minifloat_add_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] a_in = 8'h00, b_in = 8'h00;
  logic [7:0] sum_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  minifloat_add #(.OUT_REG(1)) uut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .sum_out(sum_out)
  );

  function automatic int mag(int c);
    int e = (c >> 3) & 15;
    int f = c & 7;
    return (e == 0) ? f : ((8 + f) << (e - 1));
  endfunction

  function automatic bit is_nan(logic [7:0] x);
    return (x[6:3] == 4'hF) && (x[2:0] != 3'd0);
  endfunction

  function automatic bit is_inf(logic [7:0] x);
    return x[6:0] == 7'h78;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp, logic [7:0] x, logic [7:0] y);
    checks++;
    if (act !== exp) begin
      errors++;
      if (errors <= 20)
        $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, x, y, act, exp);
    end
  endtask

  initial begin
    #2000000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R9", sum_out, 8'h00, a_in, b_in);
    @(negedge clk);
    rst_n = 1'b1;
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        logic [7:0] x, y, exp;
        string req;
        x = 8'(ia); y = 8'(ib);
        a_in = x; b_in = y;
        req = "R3";
        if (is_nan(x) || is_nan(y)) begin
          exp = 8'h7C; req = "R6";
        end else if (is_inf(x) && is_inf(y) && x[7] != y[7]) begin
          exp = 8'h7C; req = "R7";
        end else if (is_inf(x)) begin
          exp = x; req = "R7";
        end else if (is_inf(y)) begin
          exp = y; req = "R7";
        end else begin
          int sx, sy, tot, m, c, lo, hi;
          sx = x[7] ? -mag(int'(x[6:0])) : mag(int'(x[6:0]));
          sy = y[7] ? -mag(int'(y[6:0])) : mag(int'(y[6:0]));
          tot = sx + sy;
          if (tot == 0) begin
            exp = (x[7] && y[7]) ? 8'h80 : 8'h00; req = "R8";
          end else begin
            m = (tot < 0) ? -tot : tot;
            c = 0;
            for (int k = 0; k <= 8'h78; k++)
              if (mag(k) <= m) c = k;
            if (c == 8'h78) begin
              req = "R5";
            end else if (mag(c) != m) begin
              lo = mag(c); hi = mag(c + 1);
              if (2 * m > lo + hi) c = c + 1;
              else if (2 * m == lo + hi) begin
                req = "R4";
                if (c & 1) c = c + 1;
              end
            end else if (x[6:3] != 0 && y[6:3] != 0) begin
              req = "R1";
            end
            if (c == 8'h78 && req != "R4") req = "R5";
            else if (req == "R3" && (x[6:3] == 0 || y[6:3] == 0)) req = "R2";
            exp = {(tot < 0) ? 1'b1 : 1'b0, 7'(c)};
          end
        end
        @(negedge clk);
        check({req, "/R9"}, sum_out, exp, x, y);
      end
    end
    rst_n = 1'b0;
    #1;
    check("R9", sum_out, 8'h00, a_in, b_in);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule